// File: doc/BRIEF.md
# Timer Input-Capture Channel with Coherent Byte Reads

This block timestamps events on an external pin for a timer that sits on an 8-bit bus. The pin first passes through a synchronizer. When the edge kind chosen by a 2-bit select code appears, the channel copies a 16-bit free-running count into its capture register in one parallel transfer. The count is sampled on the clock phase opposite to the one on which the counter increments, so the sampled value is always settled. Software reads the captured value as two 8-bit bytes. A sticky flag reports that a transfer has happened.

Reading the high byte blocks transfers for that bus cycle. A capture that arrives during the block is held and written one cycle later, still carrying the count from the cycle of its edge. A high-byte read followed at once by a low-byte read therefore always returns both halves of the same 16-bit value. A build-time option makes the register dual-function. In that build it resets to all ones, and a mode input chooses between capturing and acting as a plain byte-writable compare register.

Top module: `ic_channel`

## Requirements
- R1: The pin passes through two synchronizer flops and an edge-history flop. A matching pin change made in cycle c is captured at the clock edge that ends cycle c+2. The stored value is the counter value present during cycle c+2, and the flag reads 1 from cycle c+3.
- R2: Edge select `edge_sel` uses these codes: 00 captures nothing, 01 captures rising edges only, 10 captures falling edges only, 11 captures both.
- R3: Reads are registered. A read strobe in cycle t shows its data on `rd_data` from cycle t+1. Address 0 returns bits 15:8 of the capture register, address 1 returns bits 7:0, and address 2 returns the flag in bit 0 with zeros above it.
- R4: A read of address 0 blocks any capture transfer at the clock edge that ends that read cycle.
- R5: A capture blocked by a high-byte read is not lost. It is written one cycle later and stores the count from the cycle of its own edge.
- R6: A high-byte read followed in the next cycle by a low-byte read returns two halves of one stored value, even when an edge lands on the high-byte read cycle.
- R7: The flag is set by every transfer and cleared by a write of 1 in bit 0 to address 2. A write of 0 leaves it unchanged. A transfer and a clear in the same cycle leave the flag set. Reset clears the flag.
- R8: In the capture-only build (DUAL_FUNC=0), reset leaves the capture register contents unchanged.
- R9: In the dual-function build (DUAL_FUNC=1), reset loads 16'hFFFF. With `mode_ic`=1 the register captures. With `mode_ic`=0 it ignores edges, and writes to address 0 and address 1 load the high and low bytes.
- R10: While capturing, writes to address 0 and address 1 have no effect on the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the counter snapshot is taken on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous event pin |
| edge_sel | input | 2 | Edge select code |
| mode_ic | input | 1 | 1 = capture, 0 = writable compare (dual-function build only) |
| count_in | input | 16 | Free-running counter value |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
Single directed edges of each polarity are applied under every select code. These separate a polarity decode that is inverted or ignored from a correct one, and the exact capture cycle exposes a missing or extra synchronizer stage. An edge placed on the very cycle of a high-byte read tells three designs apart: one that tears the byte pair, one that drops the blocked event, and one that stores a late timestamp. Random sequences of select codes and pin levels compare every stored value against a model computed in the bench. Writes, mode switching and a mid-run reset tell the two build options apart.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam logic [1:0] ADR_HI   = 2'd0;
  localparam logic [1:0] ADR_LO   = 2'd1;
  localparam logic [1:0] ADR_FLAG = 2'd2;
endpackage

// File: rtl/ic_edge_detect.sv
module ic_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       ev
);
  logic [SYNC_STAGES-1:0] sh;
  logic                   prev;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= sh[i-1];
      end
    end
  end

  assign cur = sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    unique case (sel)
      ic_pkg::EDGE_RISE: ev = rise;
      ic_pkg::EDGE_FALL: ev = fall;
      ic_pkg::EDGE_ANY:  ev = rise | fall;
      default:           ev = 1'b0;
    endcase
  end

  // R2: the disabled code never yields an event
  p_edge_off_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == ic_pkg::EDGE_OFF) |-> !ev);
  // R2: an event always coincides with a change of the synchronized level
  p_edge_change_r2: assert property (@(posedge clk) disable iff (rst)
    ev |-> (cur != prev));
endmodule

// File: rtl/ic_capture_reg.sv
module ic_capture_reg #(
  parameter int BYTE_W    = 8,
  parameter bit DUAL_FUNC = 1'b0,
  localparam int CNT_W    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev,
  input  logic [CNT_W-1:0]  cnt_snap,
  input  logic              blk,
  input  logic              cap_en,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cap_q,
  output logic              xfer
);
  logic             pend;
  logic [CNT_W-1:0] pend_val;
  logic             req;
  logic [CNT_W-1:0] src;

  assign req  = cap_en & (ev | pend);
  assign src  = ev ? cnt_snap : pend_val;
  assign xfer = req & ~blk & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (req && blk) begin
      pend     <= 1'b1;
      pend_val <= src;
    end else if (xfer) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && DUAL_FUNC) begin
      cap_q <= '1;
    end else if (xfer) begin
      cap_q <= src;
    end else if (!cap_en && !rst) begin
      if (wr_hi) cap_q[CNT_W-1:BYTE_W] <= wdata;
      if (wr_lo) cap_q[BYTE_W-1:0]     <= wdata;
    end
  end

  // R4: a blocked cycle leaves the stored value untouched
  p_block_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (blk && cap_en) |=> $stable(cap_q));
  // R5: a request meeting a block is kept pending
  p_no_loss_r5: assert property (@(posedge clk) disable iff (rst)
    (req && blk) |=> pend);
  // R5: a pending request completes once the block lifts
  p_pend_done_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && cap_en && !blk) |=> !pend);
  // R9: in compare mode without writes the value holds
  p_cmp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !wr_hi && !wr_lo) |=> $stable(cap_q));

  if (DUAL_FUNC) begin : g_dual_chk
    // R9: dual-function register leaves reset at all ones
    p_dual_reset_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cap_q == '1));
  end
endmodule

// File: rtl/ic_channel.sv
module ic_channel #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter bit DUAL_FUNC   = 1'b0,
  localparam int CNT_W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_pin,
  input  logic [1:0]        edge_sel,
  input  logic              mode_ic,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic              cap_flag
);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(ic_pkg::ADR_HI);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(ic_pkg::ADR_LO);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ic_pkg::ADR_FLAG);

  logic [CNT_W-1:0] cnt_snap;
  logic [CNT_W-1:0] cap_q;
  logic             ev;
  logic             xfer;
  logic             cap_en;
  logic             hi_rd;
  logic             wr_hi;
  logic             wr_lo;
  logic             flag_clr;

  // counter sampled on the phase opposite to its increment
  always_ff @(negedge clk) cnt_snap <= count_in;

  assign cap_en   = DUAL_FUNC ? mode_ic : 1'b1;
  assign hi_rd    = bus_rd && (bus_addr == A_HI);
  assign wr_hi    = bus_wr && (bus_addr == A_HI);
  assign wr_lo    = bus_wr && (bus_addr == A_LO);
  assign flag_clr = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];

  ic_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk (clk),
    .rst (rst),
    .pin (cap_pin),
    .sel (edge_sel),
    .ev  (ev)
  );

  ic_capture_reg #(.BYTE_W(BYTE_W), .DUAL_FUNC(DUAL_FUNC)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .cnt_snap (cnt_snap),
    .blk      (hi_rd),
    .cap_en   (cap_en),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .wdata    (bus_wdata),
    .cap_q    (cap_q),
    .xfer     (xfer)
  );

  always_ff @(posedge clk) begin
    if (rst)           cap_flag <= 1'b0;
    else if (xfer)     cap_flag <= 1'b1;
    else if (flag_clr) cap_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (bus_rd) begin
      if (bus_addr == A_HI)        rd_data <= cap_q[CNT_W-1:BYTE_W];
      else if (bus_addr == A_LO)   rd_data <= cap_q[BYTE_W-1:0];
      else if (bus_addr == A_FLAG) rd_data <= {{(BYTE_W-1){1'b0}}, cap_flag};
      else                         rd_data <= '0;
    end
  end

  // R3: high-byte read returns the upper half of the stored value
  p_rd_hi_r3: assert property (@(posedge clk) disable iff (rst)
    hi_rd |=> (rd_data == $past(cap_q[CNT_W-1:BYTE_W])));
  // R7: every transfer leaves the flag set
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    xfer |=> cap_flag);
  // R7: the flag only rises through a transfer
  p_flag_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (!xfer && !cap_flag) |=> !cap_flag);
endmodule

// File: tb/sim_ic_channel.sv
module sim_ic_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic        mode1 = 1'b1;
  logic [15:0] cnt = 16'h0100;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  rd0, rd1;
  logic        flag0, flag1;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_v = 16'h0;
  logic [15:0] v0, v1;
  logic [15:0] k;

  always #10 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  ic_channel #(.DUAL_FUNC(1'b0)) u0 (
    .clk(clk), .rst(rst), .cap_pin(pin), .edge_sel(edge_sel), .mode_ic(1'b1),
    .count_in(cnt), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd0), .cap_flag(flag0));

  ic_channel #(.DUAL_FUNC(1'b1)) u1 (
    .clk(clk), .rst(rst), .cap_pin(pin), .edge_sel(edge_sel), .mode_ic(mode1),
    .count_in(cnt), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd1), .cap_flag(flag1));

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic rd16(output logic [15:0] a0, output logic [15:0] a1);
    bus_rd = 1'b1; bus_addr = 2'd0;
    tick();
    a0[15:8] = rd0; a1[15:8] = rd1;
    bus_addr = 2'd1;
    tick();
    a0[7:0] = rd0; a1[7:0] = rd1;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  function automatic bit edge_hit(input logic [1:0] s, input logic o, input logic n);
    case (s)
      2'b01:   return !o && n;
      2'b10:   return o && !n;
      2'b11:   return o != n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic try_edge(input logic [1:0] s, input logic nv, input string tag);
    logic old;
    logic [15:0] kk;
    bit hit;
    wr(2'd2, 8'h01);
    edge_sel = s;
    old = pin;
    kk = cnt;
    pin = nv;
    repeat (4) tick();
    hit = edge_hit(s, old, nv);
    if (hit) exp_v = kk + 16'd2;
    check(flag0 == hit, {tag, " flag"}, flag0, hit);
    rd16(v0, v1);
    check(v0 == exp_v, {tag, " value"}, v0, exp_v);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check(rd0 == 8'h00, "reset rd_data R3", rd0, 0);
    check(flag0 == 1'b0, "reset flag R7", flag0, 0);
    rd16(v0, v1);
    check(v1 == 16'hFFFF, "R9 dual reset value", v1, 16'hFFFF);

    // R1 exact timing
    edge_sel = 2'b01;
    k = cnt; pin = 1'b1;
    tick(); tick();
    check(flag0 == 1'b0, "R1 flag not before c+3", flag0, 0);
    tick();
    check(flag0 == 1'b1, "R1 flag at c+3", flag0, 1);
    rd16(v0, v1);
    exp_v = k + 16'd2;
    check(v0 == exp_v, "R1 captured count", v0, exp_v);
    check(v1 == exp_v, "R9 dual captures in mode 1", v1, exp_v);

    // R3 flag readback
    bus_rd = 1'b1; bus_addr = 2'd2;
    tick();
    bus_rd = 1'b0;
    check(rd0 == 8'h01, "R3 flag readback", rd0, 1);

    // R2 edge select codes
    try_edge(2'b01, 1'b0, "R2 rise-only falling");
    try_edge(2'b10, 1'b1, "R2 fall-only rising");
    try_edge(2'b10, 1'b0, "R2 fall-only falling");
    try_edge(2'b00, 1'b1, "R2 off rising");
    try_edge(2'b11, 1'b0, "R2 any falling");
    try_edge(2'b11, 1'b1, "R2 any rising");

    // R7 write-0 keeps, write-1 clears, set wins
    wr(2'd2, 8'h00);
    check(flag0 == 1'b1, "R7 write 0 keeps flag", flag0, 1);
    wr(2'd2, 8'h01);
    check(flag0 == 1'b0, "R7 write 1 clears flag", flag0, 0);
    edge_sel = 2'b11;
    k = cnt; pin = 1'b0;
    tick(); tick();
    wr(2'd2, 8'h01);
    check(flag0 == 1'b1, "R7 set wins over clear", flag0, 1);
    exp_v = k + 16'd2;
    tick();
    wr(2'd2, 8'h01);

    // R4 R5 R6 edge on the high-byte read cycle
    begin
      logic [15:0] old_v;
      old_v = exp_v;
      k = cnt; pin = 1'b1;
      tick(); tick();
      bus_rd = 1'b1; bus_addr = 2'd0;
      tick();
      v0[15:8] = rd0;
      check(flag0 == 1'b0, "R4 transfer blocked", flag0, 0);
      bus_addr = 2'd1;
      tick();
      v0[7:0] = rd0;
      bus_rd = 1'b0;
      check(flag0 == 1'b1, "R5 delayed transfer done", flag0, 1);
      check(v0 == old_v, "R6 coherent pair", v0, old_v);
      rd16(v0, v1);
      exp_v = k + 16'd2;
      check(v0 == exp_v, "R5 edge-time count kept", v0, exp_v);
    end

    // R9 compare mode and R10 writes ignored while capturing
    mode1 = 1'b0;
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h34);
    rd16(v0, v1);
    check(v1 == 16'h1234, "R9 compare mode bytes written", v1, 16'h1234);
    check(v0 == exp_v, "R10 writes ignored when capturing", v0, exp_v);
    try_edge(2'b11, 1'b0, "R2 any falling (mode test)");
    check(v1 == 16'h1234, "R9 compare mode ignores edges", v1, 16'h1234);
    mode1 = 1'b1;
    try_edge(2'b11, 1'b1, "R1 rising");
    check(v1 == exp_v, "R9 back to capture", v1, exp_v);

    // R8 reset keeps capture-only content
    edge_sel = 2'b00;
    pin = 1'b0;
    repeat (4) tick();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
    check(flag0 == 1'b0, "R7 reset clears flag", flag0, 0);
    rd16(v0, v1);
    check(v0 == exp_v, "R8 reset keeps capture", v0, exp_v);
    check(v1 == 16'hFFFF, "R9 reset reloads ones", v1, 16'hFFFF);

    // random mix
    for (int i = 0; i < 60; i++) begin
      try_edge(2'($urandom % 4), 1'($urandom % 2), "R2 random");
    end
    check(v1 == exp_v || v1 == 16'hFFFF, "R9 dual tracks random", v1, exp_v);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule